// File: doc/BRIEF.md
# Strap-Latched Clock Configuration Controller

This block decides the working configuration of a board clock generator. While power-on reset is held, five shared pads are read as inputs. The last values seen before reset ends are kept as the hardware configuration: a 3-bit frequency code, a desktop/mobile mode flag and a CPU driver supply-level flag. After reset the pads become clock outputs. A software-written configuration byte can later replace the strapped frequency code, enable spread-spectrum modulation and choose its shape and depth, or put every output into high impedance.

The block also runs the two pins whose role depends on the mode. In desktop mode they carry a reference clock and an extra PCI clock. In mobile mode they are active-low stop inputs for the CPU and PCI clock groups, and they pass through a two-stage synchronizer. The block reports the PCI divide relation that belongs to the active frequency code. It also gives a one-cycle pulse whenever the active code changes, so a downstream synthesizer can start a smooth transition.

Top module: `clkcfg_strap_ctrl`

## Requirements
- R1: Strap pad bits are ordered [0]=FS0, [1]=FS1, [2]=FS2, [3]=mode (1 = desktop, 0 = mobile), [4]=CPU supply select (1 = 2.5 V drivers, 0 = 3.3 V). The values held after reset are those on the pads at the last clock edge of the synchronized reset window, and `strap_oe` is 0 throughout that window.
- R2: After reset is released, changes on the strap pads have no effect on `freq_sel`, `mode_desk` or `cpu_lv`, and `strap_oe` is all ones unless tristate is set.
- R3: While reset is active, `freq_sel`, `mode_desk` and `cpu_lv` follow the live pad values combinationally.
- R4: When configuration bit 3 is 1, `freq_sel` equals configuration bits 6:4 from the cycle after the write. When bit 3 is 0, `freq_sel` is the strapped code.
- R5: `pci_ratio` is 2'b01 (CPU/2.5) for code 001, 2'b10 (fixed 33.3 MHz) for code 010, and 2'b00 (CPU/2) for every other code.
- R6: In desktop mode `pin_a_out`/`pin_b_out` forward `ref_src`/`pci5_src` with their enables high, and `cpu_stop`/`pci_stop` stay 0. In mobile mode both enables are 0 and the outputs are 0. `cpu_stop` (`pci_stop`) is 1 from the second rising edge after `pin_a_in` (`pin_b_in`) goes low.
- R7: Configuration bit 0 = 1 forces `strap_oe`, `pin_a_oe` and `pin_b_oe` to 0.
- R8: `freq_change` is 1 for exactly the cycles in which `freq_sel` differs from its value in the previous cycle, only outside reset, and never at reset release.
- R9: Configuration bit 1 drives `ss_en`, bit 2 drives `ss_down` (down-spread instead of center-spread), and bit 7 drives `ss_narrow` (0.6 % instead of 1.5 % depth).
- R10: The configuration byte is 0 after reset. It changes only on a clock edge with `cfg_we` high outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous assert |
| strap_pad_in | input | 5 | Shared pad input values (strap order of R1) |
| strap_oe | output | 5 | Output enable of the shared pads |
| cfg_we | input | 1 | Configuration byte write strobe |
| cfg_wdata | input | 8 | Configuration byte write data |
| ref_src | input | 1 | Reference clock to forward on pin A in desktop mode |
| pci5_src | input | 1 | PCI clock to forward on pin B in desktop mode |
| pin_a_in | input | 1 | Pin A input value (CPU stop, active low, in mobile mode) |
| pin_a_out | output | 1 | Pin A output value |
| pin_a_oe | output | 1 | Pin A output enable |
| pin_b_in | input | 1 | Pin B input value (PCI stop, active low, in mobile mode) |
| pin_b_out | output | 1 | Pin B output value |
| pin_b_oe | output | 1 | Pin B output enable |
| freq_sel | output | 3 | Active frequency code |
| pci_ratio | output | 2 | PCI relation for the active code |
| mode_desk | output | 1 | 1 = desktop mode |
| cpu_lv | output | 1 | 1 = CPU drivers on 2.5 V supply |
| out_tristate | output | 1 | All outputs in high impedance |
| ss_en | output | 1 | Spread spectrum enabled |
| ss_down | output | 1 | Down-spread selected |
| ss_narrow | output | 1 | Narrow modulation depth selected |
| cpu_stop | output | 1 | CPU clock group stop request |
| pci_stop | output | 1 | PCI clock group stop request |
| freq_change | output | 1 | One-cycle pulse on change of the active code |

## Verification
The bench changes the pads inside the reset window and again just after it. A latch that captured too early, or one that kept following the pads, would report a code other than the one present at the last reset edge. It walks every software code with the override set, then clears the override. A wrong divide table or a sticky override would show up as a bad `pci_ratio` or a `freq_sel` that does not return to the strap. It runs a second reset with the opposite mode and drops the stop pins in both modes. A missing mode gate would stop clocks in desktop mode, and a short synchronizer would assert the stop one cycle early. The change pulse is compared on every cycle, which catches a spurious pulse at reset release or a missing pulse after a write.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int STRAP_W   = 5;
  localparam int FS_W      = 3;
  localparam int CFG_W     = 8;
  localparam int ST_MODE   = 3;
  localparam int ST_LV     = 4;
  localparam int CB_TRI    = 0;
  localparam int CB_SS_EN  = 1;
  localparam int CB_SS_DN  = 2;
  localparam int CB_OVR    = 3;
  localparam int CB_FS_LO  = 4;
  localparam int CB_SS_NW  = 7;

  typedef enum logic [1:0] {
    PCI_HALF  = 2'b00,
    PCI_DIV25 = 2'b01,
    PCI_FIXED = 2'b10
  } pci_rel_e;

  function automatic pci_rel_e pci_rel_of(input logic [FS_W-1:0] code);
    case (code)
      3'b001:  return PCI_DIV25;
      3'b010:  return PCI_FIXED;
      default: return PCI_HALF;
    endcase
  endfunction
endpackage

// File: rtl/clkcfg_rst_sync.sv
module clkcfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_ok = sh_q[STAGES-1];
endmodule

// File: rtl/clkcfg_sync_vec.sv
module clkcfg_sync_vec #(
  parameter int           W       = 2,
  parameter int           STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] st_q;
  logic [STAGES-1:0][W-1:0] st_d;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign st_d[i] = din;
    end else begin : g_next
      assign st_d[i] = st_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= {STAGES{RST_VAL}};
    else        st_q <= st_d;
  end

  assign dout = st_q[STAGES-1];
endmodule

// File: rtl/clkcfg_strap_latch.sv
module clkcfg_strap_latch #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         capture,
  input  logic [W-1:0] pads,
  output logic [W-1:0] eff
);
  logic [W-1:0] held_q;
  logic [W-1:0] held_d;

  always_comb begin
    held_d = capture ? pads : held_q;
  end

  always_ff @(posedge clk) begin
    held_q <= held_d;
  end

  // live view while the window is open, frozen copy afterwards
  assign eff = capture ? pads : held_q;
endmodule

// File: rtl/clkcfg_cfg_reg.sv
module clkcfg_cfg_reg #(
  parameter int           W       = 8,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;

  always_comb begin
    q_d = we ? wdata : q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= RST_VAL;
    else        q <= q_d;
  end
endmodule

// File: rtl/clkcfg_strap_ctrl.sv
module clkcfg_strap_ctrl
  import clkcfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_pad_in,
  output logic [STRAP_W-1:0] strap_oe,
  input  logic               cfg_we,
  input  logic [CFG_W-1:0]   cfg_wdata,
  input  logic               ref_src,
  input  logic               pci5_src,
  input  logic               pin_a_in,
  output logic               pin_a_out,
  output logic               pin_a_oe,
  input  logic               pin_b_in,
  output logic               pin_b_out,
  output logic               pin_b_oe,
  output logic [FS_W-1:0]    freq_sel,
  output logic [1:0]         pci_ratio,
  output logic               mode_desk,
  output logic               cpu_lv,
  output logic               out_tristate,
  output logic               ss_en,
  output logic               ss_down,
  output logic               ss_narrow,
  output logic               cpu_stop,
  output logic               pci_stop,
  output logic               freq_change
);
  logic               rst_ok;
  logic [STRAP_W-1:0] strap_eff;
  logic [CFG_W-1:0]   cfg_q;
  logic [FS_W-1:0]    fs_prev_q;
  logic [1:0]         stop_pins_s;
  logic               drive_ok;

  clkcfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  clkcfg_strap_latch #(.W(STRAP_W)) u_strap (
    .clk     (clk),
    .capture (!rst_ok),
    .pads    (strap_pad_in),
    .eff     (strap_eff)
  );

  clkcfg_cfg_reg #(.W(CFG_W), .RST_VAL('0)) u_cfg (
    .clk   (clk),
    .rst_n (rst_ok),
    .we    (cfg_we),
    .wdata (cfg_wdata),
    .q     (cfg_q)
  );

  clkcfg_sync_vec #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_stop_sync (
    .clk   (clk),
    .rst_n (rst_ok),
    .din   ({pin_b_in, pin_a_in}),
    .dout  (stop_pins_s)
  );

  // frequency source selection
  always_comb begin
    if (cfg_q[CB_OVR]) freq_sel = cfg_q[CB_FS_LO +: FS_W];
    else               freq_sel = strap_eff[FS_W-1:0];
  end

  assign pci_ratio = pci_rel_of(freq_sel);
  assign mode_desk = strap_eff[ST_MODE];
  assign cpu_lv    = strap_eff[ST_LV];

  // change detector: history register runs in every cycle
  always_ff @(posedge clk) begin
    fs_prev_q <= freq_sel;
  end
  assign freq_change = rst_ok && (freq_sel != fs_prev_q);

  // configuration flags
  assign out_tristate = cfg_q[CB_TRI];
  assign ss_en        = cfg_q[CB_SS_EN];
  assign ss_down      = cfg_q[CB_SS_DN];
  assign ss_narrow    = cfg_q[CB_SS_NW];

  // pad direction and mode-dependent pin reuse
  assign drive_ok  = rst_ok && !cfg_q[CB_TRI];
  assign strap_oe  = drive_ok ? '1 : '0;
  assign pin_a_oe  = drive_ok && mode_desk;
  assign pin_b_oe  = drive_ok && mode_desk;
  assign pin_a_out = mode_desk && ref_src;
  assign pin_b_out = mode_desk && pci5_src;
  assign cpu_stop  = !mode_desk && !stop_pins_s[0];
  assign pci_stop  = !mode_desk && !stop_pins_s[1];
endmodule

// File: rtl/clkcfg_strap_chk.sv
module clkcfg_strap_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       rst_ok,
  input logic       cfg_we,
  input logic [7:0] cfg_wdata,
  input logic [2:0] freq_sel,
  input logic       mode_desk,
  input logic       cpu_lv,
  input logic       out_tristate,
  input logic [4:0] strap_oe,
  input logic       pin_a_oe,
  input logic       pin_b_oe,
  input logic       cpu_stop,
  input logic       pci_stop,
  input logic       freq_change
);
  p_window_inputs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !rst_ok |-> strap_oe == 5'b0);

  p_frozen_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && $past(rst_ok)) |-> ($stable(mode_desk) && $stable(cpu_lv)));

  p_sw_override_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_ok && $past(rst_ok) && $past(cfg_we) && $past(cfg_wdata[3]))
      |-> freq_sel == $past(cfg_wdata[6:4]));

  p_desk_no_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mode_desk |-> (!cpu_stop && !pci_stop));

  p_mobile_inputs_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_desk |-> (!pin_a_oe && !pin_b_oe));

  p_tristate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_tristate |-> (strap_oe == 5'b0 && !pin_a_oe && !pin_b_oe));

  p_pulse_on_change_r8: assert property (@(posedge clk) disable iff (!rst_n)
    freq_change |-> (rst_ok && freq_sel != $past(freq_sel)));
endmodule

bind clkcfg_strap_ctrl clkcfg_strap_chk chk_i (
  .clk          (clk),
  .rst_n        (rst_n),
  .rst_ok       (rst_ok),
  .cfg_we       (cfg_we),
  .cfg_wdata    (cfg_wdata),
  .freq_sel     (freq_sel),
  .mode_desk    (mode_desk),
  .cpu_lv       (cpu_lv),
  .out_tristate (out_tristate),
  .strap_oe     (strap_oe),
  .pin_a_oe     (pin_a_oe),
  .pin_b_oe     (pin_b_oe),
  .cpu_stop     (cpu_stop),
  .pci_stop     (pci_stop),
  .freq_change  (freq_change)
);

// File: tb/clkcfg_strap_ctrl_tb_top.sv
module clkcfg_strap_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [4:0] strap_pad_in;
  logic [4:0] strap_oe;
  logic       cfg_we;
  logic [7:0] cfg_wdata;
  logic       ref_src, pci5_src;
  logic       pin_a_in, pin_a_out, pin_a_oe;
  logic       pin_b_in, pin_b_out, pin_b_oe;
  logic [2:0] freq_sel;
  logic [1:0] pci_ratio;
  logic       mode_desk, cpu_lv, out_tristate, ss_en, ss_down, ss_narrow;
  logic       cpu_stop, pci_stop, freq_change;

  int n_chk  = 0;
  int n_fail = 0;
  bit cmp_on = 0;
  bit ended  = 0;

  always #10 clk = ~clk;

  clkcfg_strap_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .strap_pad_in(strap_pad_in), .strap_oe(strap_oe),
    .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .ref_src(ref_src), .pci5_src(pci5_src),
    .pin_a_in(pin_a_in), .pin_a_out(pin_a_out), .pin_a_oe(pin_a_oe),
    .pin_b_in(pin_b_in), .pin_b_out(pin_b_out), .pin_b_oe(pin_b_oe),
    .freq_sel(freq_sel), .pci_ratio(pci_ratio), .mode_desk(mode_desk), .cpu_lv(cpu_lv),
    .out_tristate(out_tristate), .ss_en(ss_en), .ss_down(ss_down), .ss_narrow(ss_narrow),
    .cpu_stop(cpu_stop), .pci_stop(pci_stop), .freq_change(freq_change)
  );

  // ---------------- behavioural reference model ----------------
  bit         m_ok1, m_ok2;
  logic [7:0] m_cfg;
  logic [4:0] m_strap;
  logic [2:0] m_prev;
  bit         m_a [2];
  bit         m_b [2];

  function automatic logic [2:0] m_fs();
    if (!m_ok2)      return strap_pad_in[2:0];
    else if (m_cfg[3]) return m_cfg[6:4];
    else             return m_strap[2:0];
  endfunction

  function automatic logic m_mode();
    return m_ok2 ? m_strap[3] : strap_pad_in[3];
  endfunction

  function automatic logic m_lv();
    return m_ok2 ? m_strap[4] : strap_pad_in[4];
  endfunction

  function automatic logic [1:0] m_ratio(input logic [2:0] c);
    if (c == 3'd1) return 2'd1;
    if (c == 3'd2) return 2'd2;
    return 2'd0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ok1 <= 0; m_ok2 <= 0; m_cfg <= 8'h00;
      m_a[0] <= 1; m_a[1] <= 1; m_b[0] <= 1; m_b[1] <= 1;
    end else begin
      m_ok1 <= 1;
      m_ok2 <= m_ok1;
      if (!m_ok2) begin
        m_a[0] <= 1; m_a[1] <= 1; m_b[0] <= 1; m_b[1] <= 1;
      end else begin
        if (cfg_we) m_cfg <= cfg_wdata;
        m_a[0] <= pin_a_in; m_a[1] <= m_a[0];
        m_b[0] <= pin_b_in; m_b[1] <= m_b[0];
      end
    end
  end

  always @(posedge clk) begin
    if (!m_ok2) m_strap <= strap_pad_in;
    m_prev <= m_fs();
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !ended) begin
      logic [2:0] fs;
      logic       md, drv;
      fs  = m_fs();
      md  = m_mode();
      drv = m_ok2 && !m_cfg[0];
      chk("R4 freq_sel",     {5'b0, freq_sel},  {5'b0, fs});
      chk("R5 pci_ratio",    {6'b0, pci_ratio}, {6'b0, m_ratio(fs)});
      chk("R3 mode_desk",    {7'b0, mode_desk}, {7'b0, md});
      chk("R3 cpu_lv",       {7'b0, cpu_lv},    {7'b0, m_lv()});
      chk("R2 strap_oe",     {3'b0, strap_oe},  drv ? 8'h1f : 8'h00);
      chk("R6 pin_a_oe",     {7'b0, pin_a_oe},  {7'b0, drv && md});
      chk("R6 pin_b_oe",     {7'b0, pin_b_oe},  {7'b0, drv && md});
      chk("R6 pin_a_out",    {7'b0, pin_a_out}, {7'b0, md && ref_src});
      chk("R6 pin_b_out",    {7'b0, pin_b_out}, {7'b0, md && pci5_src});
      chk("R6 cpu_stop",     {7'b0, cpu_stop},  {7'b0, !md && !m_a[1]});
      chk("R6 pci_stop",     {7'b0, pci_stop},  {7'b0, !md && !m_b[1]});
      chk("R8 freq_change",  {7'b0, freq_change}, {7'b0, m_ok2 && (fs != m_prev)});
      chk("R7 out_tristate", {7'b0, out_tristate}, {7'b0, m_cfg[0]});
      chk("R9 ss_en",        {7'b0, ss_en},     {7'b0, m_cfg[1]});
      chk("R9 ss_down",      {7'b0, ss_down},   {7'b0, m_cfg[2]});
      chk("R9 ss_narrow",    {7'b0, ss_narrow}, {7'b0, m_cfg[7]});
    end
  end

  // ---------------- stimulus ----------------
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic wr(input logic [7:0] v);
    cfg_we = 1; cfg_wdata = v;
    step(1);
    cfg_we = 0;
    step(1);
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    rst_n = 0; strap_pad_in = 5'b00_101; cfg_we = 0; cfg_wdata = 8'h00;
    ref_src = 0; pci5_src = 0; pin_a_in = 1; pin_b_in = 1;
    step(2);
    cmp_on = 1;
    step(2);
    // R3: live pads while reset is active
    @(negedge clk); #1;
    chk("R3 live freq_sel", {5'b0, freq_sel}, 8'h05);
    strap_pad_in = 5'b11_011;
    #1 chk("R3 live follow", {5'b0, freq_sel}, 8'h03);
    chk("R1 strap_oe in window", {3'b0, strap_oe}, 8'h00);
    step(1);
    rst_n = 1;
    step(4);
    @(negedge clk); #1;
    chk("R1 captured fs",   {5'b0, freq_sel}, 8'h03);
    chk("R1 captured mode", {7'b0, mode_desk}, 8'h01);
    chk("R1 captured lv",   {7'b0, cpu_lv}, 8'h01);
    chk("R10 cfg reset",    {5'b0, ss_narrow, ss_en, out_tristate}, 8'h00);
    // R2: pads no longer matter
    step(1);
    strap_pad_in = 5'b00_100;
    step(3);
    @(negedge clk); #1;
    chk("R2 pads ignored fs",   {5'b0, freq_sel}, 8'h03);
    chk("R2 pads ignored mode", {7'b0, mode_desk}, 8'h01);
    // R6 desktop forwarding
    step(1);
    for (int i = 0; i < 6; i++) begin
      ref_src = ~ref_src; pci5_src = (i % 3 == 0) ? ~pci5_src : pci5_src;
      step(1);
    end
    pin_a_in = 0; pin_b_in = 0;
    step(3);
    @(negedge clk); #1;
    chk("R6 desktop ignores stop", {6'b0, pci_stop, cpu_stop}, 8'h00);
    pin_a_in = 1; pin_b_in = 1;
    step(1);
    // R4/R5 override every code
    for (int c = 0; c < 8; c++) begin
      wr({1'b0, c[2:0], 4'b1000});
      @(negedge clk); #1;
      chk("R4 override code", {5'b0, freq_sel}, {5'b0, c[2:0]});
      chk("R5 ratio", {6'b0, pci_ratio}, (c == 1) ? 8'h01 : (c == 2) ? 8'h02 : 8'h00);
      step(1);
    end
    wr(8'h00);
    @(negedge clk); #1;
    chk("R4 back to strap", {5'b0, freq_sel}, 8'h03);
    step(1);
    wr(8'b1000_0110);
    @(negedge clk); #1;
    chk("R9 spread flags", {5'b0, ss_narrow, ss_down, ss_en}, 8'h07);
    step(1);
    wr(8'h01);
    @(negedge clk); #1;
    chk("R7 tristate oe", {1'b0, pin_b_oe, pin_a_oe, strap_oe}, 8'h00);
    step(1);
    cfg_wdata = 8'hff; step(2);
    @(negedge clk); #1;
    chk("R10 no write without we", {7'b0, ss_narrow}, 8'h00);
    step(1);
    // second reset, mobile mode
    rst_n = 0; strap_pad_in = 5'b00_110;
    step(3);
    rst_n = 1;
    step(4);
    @(negedge clk); #1;
    chk("R1 second capture mode", {7'b0, mode_desk}, 8'h00);
    chk("R6 mobile oe", {6'b0, pin_b_oe, pin_a_oe}, 8'h00);
    step(1);
    pin_a_in = 0;
    step(1);
    @(negedge clk); #1;
    chk("R6 stop not yet", {7'b0, cpu_stop}, 8'h00);
    step(1);
    @(negedge clk); #1;
    chk("R6 cpu stop", {7'b0, cpu_stop}, 8'h01);
    step(1);
    pin_b_in = 0; pin_a_in = 1;
    step(2);
    @(negedge clk); #1;
    chk("R6 pci stop", {6'b0, pci_stop, cpu_stop}, 8'h02);
    step(1);
    pin_b_in = 1;
    wr(8'b0111_1000);
    @(negedge clk); #1;
    chk("R8 change after write", {5'b0, freq_sel}, 8'h07);
    step(4);
    finish_run();
  end
endmodule